// File: doc/BRIEF.md
# Pipelined Load/Store Bus Master

This block sits between a processor's load/store unit and a parallel system bus that has separate address and data paths. For each load or store the requester presents, it issues one transfer. The address phase drives the address, a size code and the direction, with an active-low request strobe. A data phase follows and lasts until the slave raises its ready input. The data path is 64 bits wide and big-endian: byte offset 0 is the most significant lane.

On a store, the block moves the right-justified store value onto the byte lanes chosen by the low address bits and the size. On a load, it picks the addressed bytes out of the returned lanes, right-justifies them, and zero- or sign-extends them to 64 bits before handing them back.

Address and data phases are pipelined. The next transfer's address phase may run alongside the current data phase. An access that would straddle an 8-byte boundary, or that carries an unknown size code, is refused with a one-cycle flag and never reaches the bus.

Top module: `lsb_master`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `bus_treq_n` is 1 and `busy`, `rsp_valid` and `misalign` are 0.
- R2: A request is accepted on a rising edge where `req_valid` is 1, `busy` is 0 and the access fits. In the cycle after that edge, `bus_treq_n` is 0 and `bus_addr`, `bus_size` and `bus_write` carry the request. If no data phase is stalled, that address phase lasts exactly one cycle.
- R3: A data phase ends on the first rising edge where `bus_ready` is 1. `rsp_valid` is 1 in exactly the cycle after that edge, and in no other cycle.
- R4: Size codes: 0 is 1 byte, 1 is 2 bytes, 2 is 3 bytes, 3 is 4 bytes and 4 is 8 bytes. Codes 5 to 7 are illegal.
- R5: Lanes are big-endian. The byte at offset o (o = address bits 2:0) sits on data bits [63-8o : 56-8o].
- R6: During a store's data phase, `bus_wdata` holds the low 8n bits of `req_wdata` (n bytes), with its most significant byte on lane o and its following bytes on the next higher lanes. All other lanes are zero.
- R7: A load with `req_signed` = 0 returns the n addressed bytes, right-justified in `rsp_rdata`, with every bit above them zero.
- R8: A load with `req_signed` = 1 returns the same bytes, with every bit above them a copy of the top bit of the byte at lane o.
- R9: A request with o + n > 8, or with an illegal size code, raises `misalign` for one cycle after the edge where it was offered with `busy` at 0. That request starts no address phase.
- R10: A new request may be accepted on the edge where the previous address phase moves into its data phase. This gives back-to-back address phases, each overlapping the previous transfer's data phase.
- R11: `busy` is 1 exactly when an address phase is pending and the data phase ahead of it is stalled (`bus_ready` 0). While that holds, the pending address, size and direction stay stable.
- R12: A store completion returns `rsp_rdata` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Requester offers an access; held until taken |
| req_write | input | 1 | 1 = store, 0 = load |
| req_size | input | 3 | Size code (R4) |
| req_signed | input | 1 | Sign-extend load data |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 64 | Store value, right-justified |
| busy | output | 1 | Request cannot be taken this cycle |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 64 | Aligned and extended load data |
| misalign | output | 1 | One-cycle refusal pulse |
| bus_treq_n | output | 1 | Active-low address-phase request |
| bus_addr | output | ADDR_W | Transfer address |
| bus_size | output | 3 | Transfer size code |
| bus_write | output | 1 | Transfer direction |
| bus_wdata | output | 64 | Store data, lane placed, during data phase |
| bus_ready | input | 1 | Slave ends the data phase |
| bus_rdata | input | 64 | Load data from slave |

## Verification
The bench builds the block with its default 32-bit address, on the fixed 64-bit data path. Every lane offset 0 to 7 and every size code, the three illegal ones included, are therefore reachable, as are all crossing cases near the 8-byte boundary. Ready patterns run from always-high, which gives back-to-back overlapped address phases, through random stalls to long stalls that keep a second address phase pending and `busy` high.

// File: rtl/lsbm_pkg.sv
package lsbm_pkg;

  localparam int DATA_W = 64;
  localparam int LANES  = DATA_W / 8;
  localparam int OFF_W  = $clog2(LANES);
  localparam int SIZE_W = 3;

  typedef enum logic [SIZE_W-1:0] {
    SZ_BYTE   = 3'd0,
    SZ_HALF   = 3'd1,
    SZ_TRIPLE = 3'd2,
    SZ_WORD   = 3'd3,
    SZ_DOUBLE = 3'd4
  } xfer_size_e;

  // State carried from the address phase into the data phase.
  typedef struct packed {
    logic [OFF_W-1:0]  off;
    logic [SIZE_W-1:0] size;
    logic              write;
    logic              sext;
  } dph_info_t;

  // Byte count for a size code; zero marks an illegal code.
  function automatic logic [OFF_W:0] size_bytes(input logic [SIZE_W-1:0] code);
    case (code)
      SZ_BYTE:   size_bytes = (OFF_W+1)'(1);
      SZ_HALF:   size_bytes = (OFF_W+1)'(2);
      SZ_TRIPLE: size_bytes = (OFF_W+1)'(3);
      SZ_WORD:   size_bytes = (OFF_W+1)'(4);
      SZ_DOUBLE: size_bytes = (OFF_W+1)'(8);
      default:   size_bytes = '0;
    endcase
  endfunction

  // True when the access has a legal size and stays inside one data beat.
  function automatic logic access_fits(input logic [OFF_W-1:0]  off,
                                       input logic [SIZE_W-1:0] code);
    logic [OFF_W+1:0] last;
    last = {2'b00, off} + {1'b0, size_bytes(code)};
    access_fits = (size_bytes(code) != '0) && (last <= (OFF_W+2)'(LANES));
  endfunction

endpackage

// File: rtl/lsbm_admit.sv
module lsbm_admit
  import lsbm_pkg::*;
(
  input  logic              req_valid,
  input  logic [OFF_W-1:0]  req_off,
  input  logic [SIZE_W-1:0] req_size,
  input  logic              aph_q,
  input  logic              dph_q,
  input  logic              bus_ready,
  output logic              aph_adv,
  output logic              dph_done,
  output logic              can_accept,
  output logic              accept,
  output logic              reject
);

  logic fits;

  always_comb begin
    fits       = access_fits(req_off, req_size);
    dph_done   = dph_q && bus_ready;
    aph_adv    = aph_q && (!dph_q || bus_ready);
    can_accept = !aph_q || aph_adv;
    accept     = req_valid && can_accept && fits;
    reject     = req_valid && can_accept && !fits;
  end

endmodule

// File: rtl/lsbm_wlanes.sv
module lsbm_wlanes
  import lsbm_pkg::*;
(
  input  logic [OFF_W-1:0]  off,
  input  logic [SIZE_W-1:0] size,
  input  logic [DATA_W-1:0] value,
  output logic [DATA_W-1:0] lanes
);

  logic [7:0] lane_b [LANES];

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    always_comb begin
      int nb;
      int o;
      int k;
      nb = int'(size_bytes(size));
      o  = int'(off);
      k  = i - o;
      lane_b[i] = 8'h00;
      if (i >= o && i < o + nb) begin
        lane_b[i] = value[8*(nb-1-k) +: 8];
      end
    end
    assign lanes[DATA_W-1-8*i -: 8] = lane_b[i];
  end

endmodule

// File: rtl/lsbm_ralign.sv
module lsbm_ralign
  import lsbm_pkg::*;
(
  input  logic [OFF_W-1:0]  off,
  input  logic [SIZE_W-1:0] size,
  input  logic              sext,
  input  logic [DATA_W-1:0] lanes,
  output logic [DATA_W-1:0] result
);

  logic       top_bit;
  logic [7:0] res_b [LANES];

  // Most significant bit of the accessed value: bit 7 of the byte at lane off.
  always_comb begin
    top_bit = lanes[DATA_W-1-8*int'(off)];
  end

  for (genvar j = 0; j < LANES; j++) begin : g_byte
    always_comb begin
      int nb;
      int src;
      nb  = int'(size_bytes(size));
      src = int'(off) + nb - 1 - j;
      if (j < nb && src >= 0 && src < LANES) begin
        res_b[j] = lanes[DATA_W-1-8*src -: 8];
      end else if (sext && top_bit) begin
        res_b[j] = 8'hFF;
      end else begin
        res_b[j] = 8'h00;
      end
    end
    assign result[8*j +: 8] = res_b[j];
  end

endmodule

// File: rtl/lsb_master.sv
module lsb_master
  import lsbm_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [SIZE_W-1:0] req_size,
  input  logic              req_signed,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              busy,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              misalign,
  output logic              bus_treq_n,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [SIZE_W-1:0] bus_size,
  output logic              bus_write,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_ready,
  input  logic [DATA_W-1:0] bus_rdata
);

  // Address-phase slot
  logic              aph_q;
  logic              aph_sext;
  logic [DATA_W-1:0] aph_wdata;

  // Data-phase slot
  logic              dph_q;
  dph_info_t         dph;

  logic aph_adv, dph_done, can_accept, accept, reject;
  logic [DATA_W-1:0] placed;
  logic [DATA_W-1:0] aligned;

  lsbm_admit u_admit (
    .req_valid  (req_valid),
    .req_off    (req_addr[OFF_W-1:0]),
    .req_size   (req_size),
    .aph_q      (aph_q),
    .dph_q      (dph_q),
    .bus_ready  (bus_ready),
    .aph_adv    (aph_adv),
    .dph_done   (dph_done),
    .can_accept (can_accept),
    .accept     (accept),
    .reject     (reject)
  );

  lsbm_wlanes u_wlanes (
    .off   (bus_addr[OFF_W-1:0]),
    .size  (bus_size),
    .value (aph_wdata),
    .lanes (placed)
  );

  lsbm_ralign u_ralign (
    .off    (dph.off),
    .size   (dph.size),
    .sext   (dph.sext),
    .lanes  (bus_rdata),
    .result (aligned)
  );

  assign busy       = !can_accept;
  assign bus_treq_n = !aph_q;

  // Address phase: loaded on accept, held while the data slot is stalled.
  always_ff @(posedge clk) begin
    if (rst) begin
      aph_q     <= 1'b0;
      aph_sext  <= 1'b0;
      aph_wdata <= '0;
      bus_addr  <= '0;
      bus_size  <= '0;
      bus_write <= 1'b0;
    end else if (accept) begin
      aph_q     <= 1'b1;
      aph_sext  <= req_signed;
      aph_wdata <= req_wdata;
      bus_addr  <= req_addr;
      bus_size  <= req_size;
      bus_write <= req_write;
    end else if (aph_adv) begin
      aph_q     <= 1'b0;
    end
  end

  // Data phase: filled from the address phase, released on ready.
  always_ff @(posedge clk) begin
    if (rst) begin
      dph_q     <= 1'b0;
      dph       <= '0;
      bus_wdata <= '0;
    end else if (aph_adv) begin
      dph_q      <= 1'b1;
      dph.off    <= bus_addr[OFF_W-1:0];
      dph.size   <= bus_size;
      dph.write  <= bus_write;
      dph.sext   <= aph_sext;
      bus_wdata  <= bus_write ? placed : '0;
    end else if (dph_done) begin
      dph_q     <= 1'b0;
      bus_wdata <= '0;
    end
  end

  // Requester-side results.
  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      misalign  <= 1'b0;
    end else begin
      rsp_valid <= dph_done;
      misalign  <= reject;
      if (dph_done) begin
        rsp_rdata <= dph.write ? '0 : aligned;
      end
    end
  end

endmodule

// File: rtl/lsbm_checker.sv
module lsbm_checker
  import lsbm_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic              rsp_valid,
  input logic              misalign,
  input logic              bus_treq_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [SIZE_W-1:0] bus_size,
  input logic              bus_write,
  input logic              bus_ready,
  input logic              dph_q
);

  p_reject_no_request_r9: assert property (@(posedge clk) disable iff (rst)
    misalign |-> bus_treq_n);

  p_fit_on_bus_r9: assert property (@(posedge clk) disable iff (rst)
    !bus_treq_n |-> access_fits(bus_addr[OFF_W-1:0], bus_size));

  p_rsp_after_ready_r3: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(dph_q && bus_ready));

  p_aph_single_cycle_r2: assert property (@(posedge clk) disable iff (rst)
    (!bus_treq_n && !dph_q) |=> dph_q);

  p_hold_while_stalled_r11: assert property (@(posedge clk) disable iff (rst)
    (!bus_treq_n && dph_q && !bus_ready) |=>
      (!bus_treq_n && $stable(bus_addr) && $stable(bus_size) && $stable(bus_write)));

  p_busy_slot_full_r11: assert property (@(posedge clk) disable iff (rst)
    busy |-> (!bus_treq_n && dph_q));

endmodule

bind lsb_master lsbm_checker #(.ADDR_W(ADDR_W)) u_lsbm_checker (
  .clk        (clk),
  .rst        (rst),
  .busy       (busy),
  .rsp_valid  (rsp_valid),
  .misalign   (misalign),
  .bus_treq_n (bus_treq_n),
  .bus_addr   (bus_addr),
  .bus_size   (bus_size),
  .bus_write  (bus_write),
  .bus_ready  (bus_ready),
  .dph_q      (dph_q)
);

// File: tb/lsb_master_tb_top.sv
module lsb_master_tb_top;

  localparam int ADDR_W = 32;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              req_valid = 1'b0;
  logic              req_write = 1'b0;
  logic [2:0]        req_size = '0;
  logic              req_signed = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [63:0]       req_wdata = '0;
  logic              busy, rsp_valid, misalign, bus_treq_n, bus_write;
  logic [63:0]       rsp_rdata, bus_wdata;
  logic [ADDR_W-1:0] bus_addr;
  logic [2:0]        bus_size;
  logic              bus_ready = 1'b0;
  logic [63:0]       bus_rdata = '0;

  always #5 clk = ~clk;

  lsb_master #(.ADDR_W(ADDR_W)) dut_i (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_write(req_write), .req_size(req_size),
    .req_signed(req_signed), .req_addr(req_addr), .req_wdata(req_wdata),
    .busy(busy), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .misalign(misalign),
    .bus_treq_n(bus_treq_n), .bus_addr(bus_addr), .bus_size(bus_size),
    .bus_write(bus_write), .bus_wdata(bus_wdata),
    .bus_ready(bus_ready), .bus_rdata(bus_rdata)
  );

  typedef struct {
    logic [ADDR_W-1:0] addr;
    logic [2:0]        size;
    logic              wr;
    logic              sx;
    logic [63:0]       wd;
  } txn_t;

  int   n_tests = 0;
  int   n_fail  = 0;
  txn_t reqq[$];

  // Reference model state
  bit          m_aph = 0, m_dph = 0;
  txn_t        m_a, m_d;
  bit          e_rsp = 0, e_mis = 0;
  logic [63:0] e_rdata = '0;
  int          e_kind = 0;

  function automatic int nbytes(input logic [2:0] s);
    case (s)
      3'd0: return 1;
      3'd1: return 2;
      3'd2: return 3;
      3'd3: return 4;
      3'd4: return 8;
      default: return 0;
    endcase
  endfunction

  function automatic bit fits(input txn_t t);
    int n = nbytes(t.size);
    return (n != 0) && (int'(t.addr[2:0]) + n <= 8);
  endfunction

  function automatic logic [63:0] place(input txn_t t);
    logic [63:0] r = '0;
    int n = nbytes(t.size);
    int o = int'(t.addr[2:0]);
    for (int k = 0; k < n; k++) r[63-8*(o+k) -: 8] = t.wd[8*(n-1-k) +: 8];
    return r;
  endfunction

  function automatic logic [63:0] extract(input txn_t t, input logic [63:0] rd);
    logic [63:0] v = '0;
    int n = nbytes(t.size);
    int o = int'(t.addr[2:0]);
    for (int k = 0; k < n; k++) v = (v << 8) | {56'd0, rd[63-8*(o+k) -: 8]};
    if (t.sx && v[8*n-1])
      for (int b = 8*n; b < 64; b++) v[b] = 1'b1;
    return v;
  endfunction

  function automatic txn_t cur_req();
    txn_t t;
    t.addr = req_addr; t.size = req_size; t.wr = req_write;
    t.sx = req_signed; t.wd = req_wdata;
    return t;
  endfunction

  function automatic bit exp_can();
    return !m_aph || (!m_dph || bus_ready);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_aph = 0; m_dph = 0; e_rsp = 0; e_mis = 0;
    end else begin
      bit   adv, done, can;
      txn_t c;
      c    = cur_req();
      adv  = m_aph && (!m_dph || bus_ready);
      done = m_dph && bus_ready;
      can  = !m_aph || adv;
      e_rsp = done;
      if (done) begin
        e_kind  = m_d.wr ? 0 : (m_d.sx ? 2 : 1);
        e_rdata = m_d.wr ? 64'd0 : extract(m_d, bus_rdata);
      end
      e_mis = req_valid && can && !fits(c);
      if (adv) begin m_d = m_a; m_dph = 1; end
      else if (done) m_dph = 0;
      if (req_valid && can && fits(c)) begin m_a = c; m_aph = 1; end
      else if (adv) m_aph = 0;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
    end
  endtask

  task automatic compare();
    logic eb;
    eb = m_aph && m_dph && !bus_ready;
    chk(busy === eb, "R11 busy", {63'd0, busy}, {63'd0, eb});
    chk(bus_treq_n === !m_aph, "R2 R10 treq_n", {63'd0, bus_treq_n}, {63'd0, !m_aph});
    if (m_aph) begin
      chk(bus_addr === m_a.addr, "R2 addr", {32'd0, bus_addr}, {32'd0, m_a.addr});
      chk(bus_size === m_a.size && bus_write === m_a.wr, "R2 R4 size/dir",
          {60'd0, bus_size, bus_write}, {60'd0, m_a.size, m_a.wr});
    end
    chk(rsp_valid === e_rsp, "R3 rsp_valid", {63'd0, rsp_valid}, {63'd0, e_rsp});
    if (e_rsp) begin
      if (e_kind == 0)      chk(rsp_rdata === e_rdata, "R12 store rdata", rsp_rdata, e_rdata);
      else if (e_kind == 1) chk(rsp_rdata === e_rdata, "R7 R5 zero-ext load", rsp_rdata, e_rdata);
      else                  chk(rsp_rdata === e_rdata, "R8 R5 sign-ext load", rsp_rdata, e_rdata);
    end
    chk(misalign === e_mis, "R9 misalign", {63'd0, misalign}, {63'd0, e_mis});
    if (m_dph && m_d.wr)
      chk(bus_wdata === place(m_d), "R6 R5 store lanes", bus_wdata, place(m_d));
  endtask

  task automatic add(input logic [ADDR_W-1:0] a, input logic [2:0] s, input bit w,
                     input bit x, input logic [63:0] d);
    txn_t t;
    t.addr = a; t.size = s; t.wr = w; t.sx = x; t.wd = d;
    reqq.push_back(t);
  endtask

  initial begin
    int  cyc = 0;
    int  idx = 0;
    bit  presenting = 0;
    bit  timed_out = 0;
    // Directed corner cases (R4, R5, R9 boundaries)
    add(32'h1000_0004, 3'd3, 1, 0, 64'h0000_0000_DEAD_BEEF);
    add(32'h1000_0007, 3'd0, 0, 1, 64'd0);
    add(32'h1000_0005, 3'd2, 0, 1, 64'd0);
    add(32'h1000_0005, 3'd2, 1, 0, 64'h0000_0000_00AB_CDEF);
    add(32'h1000_0006, 3'd2, 0, 0, 64'd0);
    add(32'h1000_0000, 3'd4, 1, 0, 64'h0123_4567_89AB_CDEF);
    add(32'h1000_0009, 3'd4, 0, 0, 64'd0);
    add(32'h1000_0007, 3'd1, 0, 0, 64'd0);
    add(32'h1000_0000, 3'd5, 0, 0, 64'd0);
    add(32'h1000_0002, 3'd1, 0, 1, 64'd0);
    for (int i = 0; i < 300; i++)
      add($urandom, 3'($urandom_range(0, 5)), 1'($urandom), 1'($urandom),
          {$urandom, $urandom});

    repeat (2) @(posedge clk);
    @(negedge clk); #1;
    chk(bus_treq_n === 1'b1 && busy === 1'b0 && rsp_valid === 1'b0 && misalign === 1'b0,
        "R1 reset state", {60'd0, bus_treq_n, busy, rsp_valid, misalign}, 64'h8);
    rst = 1'b0;
    @(negedge clk); #1;
    chk(bus_treq_n === 1'b1 && rsp_valid === 1'b0 && misalign === 1'b0,
        "R1 first cycle", {61'd0, bus_treq_n, rsp_valid, misalign}, 64'h4);

    while (reqq.size() > 0) begin
      @(negedge clk);
      cyc++;
      if (cyc > 50000) begin timed_out = 1; break; end
      // Ready pattern: always high (R10), random, then long stalls (R11)
      if (idx < 80)       bus_ready = 1'b1;
      else if (idx < 200) bus_ready = 1'($urandom);
      else                bus_ready = ($urandom_range(0, 4) == 0);
      bus_rdata = {$urandom, $urandom};
      if (!presenting && (idx < 80 || $urandom_range(0, 3) != 0)) presenting = 1;
      req_valid  = presenting;
      req_addr   = reqq[0].addr;
      req_size   = reqq[0].size;
      req_write  = reqq[0].wr;
      req_signed = reqq[0].sx;
      req_wdata  = reqq[0].wd;
      #1;
      compare();
      if (presenting && exp_can()) begin
        void'(reqq.pop_front());
        presenting = 0;
        idx++;
      end
    end
    req_valid = 1'b0;
    bus_ready = 1'b1;
    repeat (10) begin
      @(negedge clk); #1;
      compare();
    end
    if (timed_out) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule